// File: doc/BRIEF.md
# Sample Buffer with Data-Available Signalling

This block is a small first-in first-out store that sits between a conversion engine and a host processor. The engine pushes one 12-bit word for each converted channel. The host reads the oldest word from a read-data port that always shows the head entry, and a pop strobe removes that entry. The block reports how many words it holds. A sticky overflow flag records any push that met a full buffer. A data-available output tells the host that there is data to fetch. The host sets three things for that output: its polarity, whether it is a steady level or a one-cycle pulse, and a fill-level threshold.

The data-available output comes from a three-state machine. In `AV_BELOW` the fill count is below the effective threshold. `AV_BELOW` goes to `AV_RISE` when the count reaches the threshold. `AV_RISE` lasts exactly one cycle: it moves to `AV_ABOVE` if the count is still at or above the threshold, and otherwise back to `AV_BELOW`. `AV_ABOVE` returns to `AV_BELOW` once the count falls below the threshold. A buffer clear forces `AV_BELOW` from any state. Level mode is active in `AV_RISE` and `AV_ABOVE`; pulse mode is active only in `AV_RISE`. The depth parameter must be a power of two.

Top module: `sample_buffer`

## Requirements
- R1: While `rst_n` is low and after it is released, `fill` is 0, `overflow` is 0 and `data_av` is at its inactive level (0 when `avail_pol` is 1).
- R2: Words leave in the order they were pushed. `rd_data` shows the oldest stored word whenever `fill` > 0. An accepted push raises `fill` by one and an accepted pop lowers it by one, visible after the clock edge that samples the strobe.
- R3: A push sampled while `fill` is 16 is discarded, and the stored words and their order stay unchanged. If a pop comes in the same cycle, the pop is still taken, so `fill` becomes 15.
- R4: `overflow` goes to 1 on the edge that samples a push while `fill` is 16. It stays 1 through later pushes and pops, and only `rst_n` low or `fifo_clr` returns it to 0.
- R5: `fifo_clr` empties the buffer and clears `overflow` on the next edge. It takes precedence over a push or pop in the same cycle, which are then dropped. Threshold, polarity and mode are not disturbed.
- R6: A push and a pop in the same cycle with 0 < `fill` < 16 leave `fill` unchanged: the old head leaves and the new word joins at the tail.
- R7: A pop sampled while `fill` is 0 has no effect: `fill` stays 0 and `overflow` is unchanged.
- R8: In level mode (`avail_pulse` = 0), `data_av` is active while `fill` is at or above the effective threshold and inactive below it. It follows a change of `fill` one clock edge later.
- R9: In pulse mode (`avail_pulse` = 1), `data_av` is active for exactly one cycle each time `fill` goes from below the threshold to at or above it. It is inactive while `fill` stays at or above the threshold.
- R10: `avail_pol` = 1 makes `data_av` active high; `avail_pol` = 0 makes it active low.
- R11: The effective threshold is `trig_level`, except that 0 is treated as 1 and any value above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous global reset, active low |
| fifo_clr | input | 1 | Synchronous buffer clear |
| push | input | 1 | Push strobe from the conversion engine |
| push_data | input | 12 | Word to store |
| pop | input | 1 | Pop strobe from the host |
| trig_level | input | 5 | Fill threshold for data-available (1 to 16) |
| avail_pol | input | 1 | 1: data_av active high, 0: active low |
| avail_pulse | input | 1 | 1: pulse mode, 0: level mode |
| rd_data | output | 12 | Oldest stored word |
| data_av | output | 1 | Data-available indication |
| overflow | output | 1 | Sticky overflow flag |
| fill | output | 5 | Number of stored words, 0 to 16 |

## Verification
`fill`, `overflow` and `rd_data` change on the first rising edge after a strobe is sampled. `data_av` trails `fill` by one more edge, so a pulse appears two edges after the crossing push and is gone one edge later. The bench drives its strobes on the falling edge. It samples one nanosecond after a later falling edge: one falling edge later for the count and flag, and two for the data-available output. The scoreboard monitor compares `rd_data` in the same low phase in which a pop is presented, before that pop is sampled.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    // States of the data-available tracker
    typedef enum logic [1:0] {
        AV_BELOW = 2'd0,   // fill under threshold
        AV_RISE  = 2'd1,   // first cycle at or above threshold
        AV_ABOVE = 2'd2    // remaining cycles at or above threshold
    } av_state_e;

endpackage

// File: rtl/sbuf_store.sv
module sbuf_store #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 12,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    fill,
    output logic             overflow
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             ovf_q;
    logic             is_full;
    logic             is_empty;
    logic             take_push;
    logic             take_pop;

    always_comb begin
        is_full   = (cnt == CW'(DEPTH));
        is_empty  = (cnt == '0);
        take_push = push && !is_full && !clr;
        take_pop  = pop && !is_empty && !clr;
    end

    // Storage array, no reset needed
    always_ff @(posedge clk) begin
        if (take_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf_q  <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (take_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (take_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({take_push, take_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push && is_full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign rd_data  = mem[rd_ptr];
    assign fill     = cnt;
    assign overflow = ovf_q;

endmodule

// File: rtl/sbuf_avail.sv
module sbuf_avail
    import sbuf_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] trig,
    input  logic          pol,
    input  logic          pulse_mode,
    output logic          av
);

    av_state_e     state_q;
    av_state_e     state_d;
    logic [CW-1:0] eff_trig;
    logic          hit;
    logic          active;

    // Clamp the threshold into 1..DEPTH
    always_comb begin
        if (trig == '0) begin
            eff_trig = CW'(1);
        end else if (trig > CW'(DEPTH)) begin
            eff_trig = CW'(DEPTH);
        end else begin
            eff_trig = trig;
        end
        hit = (fill >= eff_trig);
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = AV_BELOW;
        end else begin
            unique case (state_q)
                AV_BELOW: if (hit) state_d = AV_RISE;
                AV_RISE:  state_d = hit ? AV_ABOVE : AV_BELOW;
                AV_ABOVE: if (!hit) state_d = AV_BELOW;
                default:  state_d = AV_BELOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AV_BELOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        if (pulse_mode) begin
            active = (state_q == AV_RISE);
        end else begin
            active = (state_q != AV_BELOW);
        end
        av = pol ? active : !active;
    end

endmodule

// File: rtl/sample_buffer.sv
module sample_buffer #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 12,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic [CW-1:0]    trig_level,
    input  logic             avail_pol,
    input  logic             avail_pulse,
    output logic [WIDTH-1:0] rd_data,
    output logic             data_av,
    output logic             overflow,
    output logic [CW-1:0]    fill
);

    logic [CW-1:0] fill_w;

    sbuf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .rd_data   (rd_data),
        .fill      (fill_w),
        .overflow  (overflow)
    );

    sbuf_avail #(.DEPTH(DEPTH)) u_avail (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .fill       (fill_w),
        .trig       (trig_level),
        .pol        (avail_pol),
        .pulse_mode (avail_pulse),
        .av         (data_av)
    );

    assign fill = fill_w;

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 12,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_clr,
    input logic             push,
    input logic             pop,
    input logic [CW-1:0]    trig_level,
    input logic             avail_pol,
    input logic             avail_pulse,
    input logic [WIDTH-1:0] rd_data,
    input logic             data_av,
    input logic             overflow,
    input logic [CW-1:0]    fill
);

    logic trig_ok;
    logic act;

    assign trig_ok = (trig_level != '0) && (trig_level <= CW'(DEPTH));
    assign act     = (data_av == avail_pol);

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    assert_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !fifo_clr && fill == CW'(DEPTH)
        |=> fill == CW'(DEPTH) && $stable(rd_data));

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push && !fifo_clr && fill == CW'(DEPTH) |=> overflow);

    assert_ovf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !fifo_clr |=> overflow);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> fill == '0 && !overflow);

    assert_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !fifo_clr && fill != '0 && fill != CW'(DEPTH)
        |=> $stable(fill));

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && !fifo_clr && fill == '0 |=> fill == '0);

    assert_level_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !avail_pulse && !fifo_clr && trig_ok && fill >= trig_level
        |=> avail_pulse || act);

    assert_level_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ok && fill < trig_level |=> avail_pulse || !act);

    assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        avail_pulse && act |=> !avail_pulse || !act);

endmodule

bind sample_buffer sbuf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_clr    (fifo_clr),
    .push        (push),
    .pop         (pop),
    .trig_level  (trig_level),
    .avail_pol   (avail_pol),
    .avail_pulse (avail_pulse),
    .rd_data     (rd_data),
    .data_av     (data_av),
    .overflow    (overflow),
    .fill        (fill)
);

// File: tb/sim_sample_buffer.sv
`timescale 1ns/1ps
module sim_sample_buffer;

    localparam int DEPTH = 16;
    localparam int WIDTH = 12;
    localparam int CW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_clr = 1'b0;
    logic             push = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic             pop = 1'b0;
    logic [CW-1:0]    trig_level = CW'(4);
    logic             avail_pol = 1'b1;
    logic             avail_pulse = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             data_av;
    logic             overflow;
    logic [CW-1:0]    fill;

    int               n_chk = 0;
    int               n_bad = 0;
    logic [WIDTH-1:0] exp_q[$];
    int               m_fill = 0;
    bit               mon_pop = 1'b0;

    always #2.5 clk = ~clk;

    sample_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .push(push),
        .push_data(push_data), .pop(pop), .trig_level(trig_level),
        .avail_pol(avail_pol), .avail_pulse(avail_pulse), .rd_data(rd_data),
        .data_av(data_av), .overflow(overflow), .fill(fill)
    );

    task automatic check(string req, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Driver: presents strobes on the falling edge and updates the model
    task automatic drive(bit p, logic [WIDTH-1:0] d, bit q);
        bit acc_p;
        bit acc_q;
        @(negedge clk);
        acc_p     = p && (m_fill < DEPTH);
        acc_q     = q && (m_fill > 0);
        push      = p;
        push_data = d;
        pop       = q;
        fifo_clr  = 1'b0;
        mon_pop   = acc_q;
        if (acc_p) exp_q.push_back(d);
        m_fill = m_fill + (acc_p ? 1 : 0) - (acc_q ? 1 : 0);
    endtask

    task automatic idle();
        @(negedge clk);
        push     = 1'b0;
        pop      = 1'b0;
        fifo_clr = 1'b0;
        mon_pop  = 1'b0;
    endtask

    // Clear with a competing push that must be dropped (R5)
    task automatic clear_fifo();
        @(negedge clk);
        fifo_clr  = 1'b1;
        push      = 1'b1;
        push_data = 12'h5A5;
        pop       = 1'b0;
        mon_pop   = 1'b0;
        exp_q.delete();
        m_fill = 0;
    endtask

    // Scoreboard monitor: compares the head word with the model before each pop
    always @(negedge clk) begin
        #1;
        if (mon_pop) begin
            check("R2 head order", int'(rd_data), int'(exp_q[0]));
            void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        check("R1 fill in reset", int'(fill), 0);
        check("R1 overflow in reset", int'(overflow), 0);
        check("R1 data_av in reset", int'(data_av), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        #1;
        check("R1 fill after release", int'(fill), 0);
        check("R1 data_av after release", int'(data_av), 0);

        // R8 level mode, threshold 4
        drive(1'b1, 12'h101, 1'b0);
        drive(1'b1, 12'h102, 1'b0);
        drive(1'b1, 12'h103, 1'b0);
        idle(); idle(); #1;
        check("R2 fill count", int'(fill), 3);
        check("R8 below threshold", int'(data_av), 0);
        drive(1'b1, 12'h104, 1'b0);
        idle(); #1;
        check("R2 fill count", int'(fill), 4);
        check("R8 one edge latency", int'(data_av), 0);
        idle(); #1;
        check("R8 at threshold", int'(data_av), 1);
        drive(1'b0, '0, 1'b1);
        idle(); idle(); #1;
        check("R2 fill after pop", int'(fill), 3);
        check("R8 drops below threshold", int'(data_av), 0);

        // R6 simultaneous push and pop
        drive(1'b1, 12'h105, 1'b1);
        drive(1'b1, 12'h106, 1'b1);
        idle(); #1;
        check("R6 fill unchanged", int'(fill), 3);
        repeat (3) drive(1'b0, '0, 1'b1);

        // R7 pop while empty
        drive(1'b0, '0, 1'b1);
        idle(); #1;
        check("R7 fill stays zero", int'(fill), 0);
        check("R7 overflow unchanged", int'(overflow), 0);

        // R3 / R4 full buffer
        for (int i = 0; i < DEPTH; i++) drive(1'b1, 12'h200 + WIDTH'(i), 1'b0);
        drive(1'b1, 12'hEEE, 1'b0);
        idle(); #1;
        check("R3 fill stays full", int'(fill), 16);
        check("R3 head unchanged", int'(rd_data), 'h200);
        check("R4 overflow set", int'(overflow), 1);
        drive(1'b1, 12'hDDD, 1'b1);
        idle(); #1;
        check("R3 pop taken push dropped", int'(fill), 15);
        for (int i = 0; i < DEPTH - 1; i++) drive(1'b0, '0, 1'b1);
        idle(); #1;
        check("R3 drained", int'(fill), 0);
        check("R4 overflow sticky", int'(overflow), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R4 cleared by global reset", int'(overflow), 0);

        // R5 buffer clear
        for (int i = 0; i < DEPTH; i++) drive(1'b1, 12'h300 + WIDTH'(i), 1'b0);
        drive(1'b1, 12'h3FF, 1'b0);
        idle(); #1;
        check("R4 overflow set again", int'(overflow), 1);
        clear_fifo();
        idle(); #1;
        check("R5 fill cleared", int'(fill), 0);
        check("R5 overflow cleared", int'(overflow), 0);
        for (int i = 0; i < 4; i++) drive(1'b1, 12'h310 + WIDTH'(i), 1'b0);
        idle(); idle(); #1;
        check("R5 threshold kept", int'(data_av), 1);
        check("R5 clear-cycle push dropped", int'(rd_data), 'h310);
        clear_fifo();
        idle(); #1;
        check("R5 fill cleared again", int'(fill), 0);

        // R9 pulse mode, threshold 2
        avail_pulse = 1'b1;
        trig_level  = CW'(2);
        idle(); idle();
        drive(1'b1, 12'h401, 1'b0);
        drive(1'b1, 12'h402, 1'b0);
        idle(); #1;
        check("R9 no pulse yet", int'(data_av), 0);
        idle(); #1;
        check("R9 pulse on crossing", int'(data_av), 1);
        idle(); #1;
        check("R9 pulse single cycle", int'(data_av), 0);
        drive(1'b1, 12'h403, 1'b0);
        idle(); idle(); #1;
        check("R9 no pulse while above", int'(data_av), 0);
        drive(1'b0, '0, 1'b1);
        drive(1'b0, '0, 1'b1);
        idle(); idle();
        drive(1'b1, 12'h404, 1'b0);
        idle(); idle(); #1;
        check("R9 second crossing pulse", int'(data_av), 1);

        // R10 polarity, level mode, fill 2
        avail_pulse = 1'b0;
        avail_pol   = 1'b0;
        idle(); idle(); #1;
        check("R10 active low asserted", int'(data_av), 0);
        trig_level = CW'(3);
        idle(); idle(); #1;
        check("R10 active low idle", int'(data_av), 1);

        // R11 threshold clamp
        avail_pol = 1'b1;
        clear_fifo();
        trig_level = CW'(0);
        idle(); idle(); #1;
        check("R11 zero threshold empty", int'(data_av), 0);
        drive(1'b1, 12'h501, 1'b0);
        idle(); idle(); #1;
        check("R11 zero acts as one", int'(data_av), 1);
        trig_level = CW'(20);
        idle(); idle(); #1;
        check("R11 large threshold not met", int'(data_av), 0);
        for (int i = 0; i < DEPTH - 1; i++) drive(1'b1, 12'h502 + WIDTH'(i), 1'b0);
        idle(); idle(); #1;
        check("R11 large acts as sixteen", int'(data_av), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule